// File: doc/BRIEF.md
# Dead-Time-Preserving Current-Limit PWM

This block is a counter-based PWM generator with a complementary pair of outputs, A and B, and a third output, C, that runs on its own. An up-counter sets the period. A is high at the start of each period until a compare point. B rises one signed dead time after A's falling edge. A negative dead time makes the two outputs overlap.

An asynchronous current-limit input can cut the pulses short, once per period. When a limit event arrives while A is high, A falls early and B's rising edge moves by the same amount, so the dead time stays the same. With a negative dead time, B rises at the event and A stays high for the dead-time magnitude after it. Output C has its own limit enable. A one-cycle sync pulse is normally emitted at a programmed count, and it can be advanced to the moment of the limit event.

The period, compares, sync count and dead time are held in shadow registers. These are loaded during reset and on the last count of each period.

Top module: `dtcl_pwm`

## Requirements
- R1: The counter runs from 0 to period-1 and then wraps (period of at least 2). With the shadow values of the current period and no limit event, output A is high for counts below the A compare. B is high for counts at or above A compare + dead time, where dead time is signed two's complement. C is high for counts below the C compare. Each output shows the value for count c one clock after the counter held c.
- R2: The limit input passes through two synchronizer flops, so the event count e is the counter value in the cycle when the synchronized input is first high in a period. An event is acted on when A/B limiting is enabled, e is below the A fall point, and B has not yet risen. With a dead time of zero or more, A is then low from count e and B rises at e + dead time.
- R3: For an acted-on event with a negative dead time, B is high from count e and A stays high through count e+|dead time|-1. A is therefore never cut shorter than the dead-time magnitude after the event.
- R4: An event that arrives after A has fallen, or after B has risen, leaves A and B as they would be without it. The same holds for any event while A/B limiting is disabled.
- R5: While C limiting is enabled, an event at count e below the C compare makes C low from count e. This does not depend on the A/B enable.
- R6: Only the first synchronized event in a period has any effect. A later event in the same period changes no output. The event state clears at the start of the next period.
- R7: Sync-out is a one-cycle pulse, at most one per period. It falls on the programmed sync count, or it never fires if that count is not below the period. With sync advance enabled, it falls on the event count e instead when e is earlier than the programmed count.
- R8: A change of period, compare, sync count or dead time made in the middle of a period first takes effect in the following period.
- R9: While reset is asserted, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the shadow registers |
| lim_i | input | 1 | Asynchronous current-limit request |
| en_ab_i | input | 1 | Limit enable for the A/B pair |
| en_c_i | input | 1 | Limit enable for output C |
| adv_sync_i | input | 1 | Advance sync-out to the limit event |
| period_i | input | CNT_W | Period length in clocks |
| cmp_a_i | input | CNT_W | A falling-edge compare |
| cmp_c_i | input | CNT_W | C falling-edge compare |
| sync_at_i | input | CNT_W | Programmed sync-out count |
| dead_i | input | DT_W | Signed dead time from A fall to B rise |
| pwm_a_o | output | 1 | Output A |
| pwm_b_o | output | 1 | Output B |
| pwm_c_o | output | 1 | Output C |
| sync_o | output | 1 | Sync-out pulse |

## Verification
The assertions check, on every cycle, that the counter stays inside the period and that A and C never run past their shadow compares. They also check that A and B overlap only under a negative dead time, that each sync pulse has a cause (the programmed count or an advanced limit event), and that reset silences the outputs. Only the bench scenarios can show where the truncated edges actually land. These cover B following A's early fall by exactly the dead time, the negative-dead-time ordering, late or second events being ignored, and mid-period writes waiting for the next period. The bench checks these by comparing every output on every cycle with a model driven from the requirements.

// File: rtl/dtcl_pkg.sv
package dtcl_pkg;
  // flops between the asynchronous limit pin and the event logic
  localparam int LIM_SYNC_STAGES = 2;
endpackage

// File: rtl/dtcl_sync.sv
module dtcl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dtcl_timebase.sv
module dtcl_timebase #(
  parameter int CNT_W = 8,
  parameter int DT_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CNT_W-1:0]        per_i,
  input  logic [CNT_W-1:0]        cmp_a_i,
  input  logic [CNT_W-1:0]        cmp_c_i,
  input  logic [CNT_W-1:0]        sync_at_i,
  input  logic signed [DT_W-1:0]  dt_i,
  output logic [CNT_W-1:0]        cnt,
  output logic                    wrap,
  output logic [CNT_W-1:0]        per_s,
  output logic [CNT_W-1:0]        cmp_a_s,
  output logic [CNT_W-1:0]        cmp_c_s,
  output logic [CNT_W-1:0]        sync_s,
  output logic signed [DT_W-1:0]  dt_s
);
  assign wrap = (cnt == per_s - CNT_W'(1));

  always_ff @(posedge clk) begin
    // shadows follow the inputs in reset and reload on the last count
    if (rst || wrap) begin
      per_s   <= per_i;
      cmp_a_s <= cmp_a_i;
      cmp_c_s <= cmp_c_i;
      sync_s  <= sync_at_i;
      dt_s    <= dt_i;
    end
    if (rst || wrap) cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/dtcl_ablimit.sv
module dtcl_ablimit #(
  parameter int CNT_W = 8,
  parameter int DT_W  = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CNT_W-1:0]       cnt,
  input  logic                   wrap,
  input  logic [CNT_W-1:0]       cmp_s,
  input  logic signed [DT_W-1:0] dt_s,
  input  logic                   ev,
  output logic                   a_o,
  output logic                   b_o
);
  localparam int SW = CNT_W + 2;

  logic signed [SW-1:0] cnt_x, cmp_x, dt_x, dneg;
  logic signed [SW-1:0] fa_cur, fa_new, fa_eff, fa_cut;
  logic cut, take;

  assign cnt_x  = $signed({2'b00, cnt});
  assign cmp_x  = $signed({2'b00, cmp_s});
  assign dt_x   = $signed({{(SW-DT_W){dt_s[DT_W-1]}}, dt_s});
  assign dneg   = dt_x[SW-1] ? dt_x : '0;
  assign fa_cur = cut ? fa_cut : cmp_x;
  // act only while A is still high and B has not yet risen
  assign take   = ev && (cnt_x < fa_cur) && (cnt_x < fa_cur + dneg);
  // negative dead time: B rises now, A holds for the magnitude
  assign fa_new = dt_x[SW-1] ? (cnt_x - dt_x) : cnt_x;
  assign fa_eff = take ? fa_new : fa_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      cut    <= 1'b0;
      fa_cut <= '0;
      a_o    <= 1'b0;
      b_o    <= 1'b0;
    end else begin
      a_o <= (cnt_x < fa_eff);
      b_o <= (cnt_x >= fa_eff + dt_x);
      if (wrap) cut <= 1'b0;
      else if (take) begin
        cut    <= 1'b1;
        fa_cut <= fa_new;
      end
    end
  end
endmodule

// File: rtl/dtcl_pwm.sv
module dtcl_pwm
  import dtcl_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DT_W  = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lim_i,
  input  logic                   en_ab_i,
  input  logic                   en_c_i,
  input  logic                   adv_sync_i,
  input  logic [CNT_W-1:0]       period_i,
  input  logic [CNT_W-1:0]       cmp_a_i,
  input  logic [CNT_W-1:0]       cmp_c_i,
  input  logic [CNT_W-1:0]       sync_at_i,
  input  logic signed [DT_W-1:0] dead_i,
  output logic                   pwm_a_o,
  output logic                   pwm_b_o,
  output logic                   pwm_c_o,
  output logic                   sync_o
);
  logic lim_s, wrap, seen, first_ev;
  logic [CNT_W-1:0] cnt, per_s, cmp_a_s, cmp_c_s, sync_s;
  logic signed [DT_W-1:0] dt_s;

  dtcl_sync #(.STAGES(LIM_SYNC_STAGES)) u_lsync (
    .clk(clk), .rst(rst), .d(lim_i), .q(lim_s)
  );

  dtcl_timebase #(.CNT_W(CNT_W), .DT_W(DT_W)) u_tbase (
    .clk(clk), .rst(rst), .per_i(period_i), .cmp_a_i(cmp_a_i),
    .cmp_c_i(cmp_c_i), .sync_at_i(sync_at_i), .dt_i(dead_i),
    .cnt(cnt), .wrap(wrap), .per_s(per_s), .cmp_a_s(cmp_a_s),
    .cmp_c_s(cmp_c_s), .sync_s(sync_s), .dt_s(dt_s)
  );

  // one event per period, shared by A/B, C and sync
  assign first_ev = lim_s & ~seen;

  always_ff @(posedge clk) begin
    if (rst || wrap) seen <= 1'b0;
    else             seen <= seen | lim_s;
  end

  dtcl_ablimit #(.CNT_W(CNT_W), .DT_W(DT_W)) u_ab (
    .clk(clk), .rst(rst), .cnt(cnt), .wrap(wrap), .cmp_s(cmp_a_s),
    .dt_s(dt_s), .ev(first_ev & en_ab_i), .a_o(pwm_a_o), .b_o(pwm_b_o)
  );

  // output C: independent truncation
  logic cut_c, take_c;
  logic [CNT_W-1:0] fc_cut, fc_eff;

  assign take_c = first_ev && en_c_i && (cnt < cmp_c_s);
  assign fc_eff = take_c ? cnt : (cut_c ? fc_cut : cmp_c_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      cut_c   <= 1'b0;
      fc_cut  <= '0;
      pwm_c_o <= 1'b0;
    end else begin
      pwm_c_o <= (cnt < fc_eff);
      if (wrap) cut_c <= 1'b0;
      else if (take_c) begin
        cut_c  <= 1'b1;
        fc_cut <= cnt;
      end
    end
  end

  // sync-out: programmed count, or the limit event when advanced
  logic sync_done, sync_fire;

  assign sync_fire = ~sync_done & ((cnt == sync_s) | (adv_sync_i & first_ev));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_done <= 1'b0;
      sync_o    <= 1'b0;
    end else begin
      sync_o <= sync_fire;
      if (wrap) sync_done <= 1'b0;
      else      sync_done <= sync_done | sync_fire;
    end
  end
endmodule

// File: rtl/dtcl_pwm_chk.sv
module dtcl_pwm_chk #(
  parameter int CNT_W = 8,
  parameter int DT_W  = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   adv_sync_i,
  input logic                   lim_s,
  input logic [CNT_W-1:0]       cnt,
  input logic [CNT_W-1:0]       per_s,
  input logic [CNT_W-1:0]       cmp_a_s,
  input logic [CNT_W-1:0]       cmp_c_s,
  input logic [CNT_W-1:0]       sync_s,
  input logic signed [DT_W-1:0] dt_s,
  input logic                   pwm_a_o,
  input logic                   pwm_b_o,
  input logic                   pwm_c_o,
  input logic                   sync_o
);
  // R9: reset silences every output
  p_rst_quiet_r9: assert property (@(posedge clk)
    rst |=> !(pwm_a_o || pwm_b_o || pwm_c_o || sync_o));

  // R1: counter stays inside the period
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt < per_s);

  // R2: truncation never extends A beyond its compare
  p_a_bounded_r2: assert property (@(posedge clk) disable iff (rst)
    pwm_a_o |-> ($past(cnt) < $past(cmp_a_s)));

  // R3: A and B overlap only with a negative dead time
  p_overlap_neg_r3: assert property (@(posedge clk) disable iff (rst)
    (pwm_a_o && pwm_b_o) |-> ($past(dt_s) < 0));

  // R5: C never extends beyond its compare
  p_c_bounded_r5: assert property (@(posedge clk) disable iff (rst)
    pwm_c_o |-> ($past(cnt) < $past(cmp_c_s)));

  // R7: each sync pulse has a cause
  p_sync_cause_r7: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> (($past(cnt) == $past(sync_s)) || ($past(lim_s) && $past(adv_sync_i))));
endmodule

bind dtcl_pwm dtcl_pwm_chk #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chk (
  .clk(clk), .rst(rst), .adv_sync_i(adv_sync_i), .lim_s(lim_s), .cnt(cnt),
  .per_s(per_s), .cmp_a_s(cmp_a_s), .cmp_c_s(cmp_c_s), .sync_s(sync_s),
  .dt_s(dt_s), .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o), .pwm_c_o(pwm_c_o),
  .sync_o(sync_o)
);

// File: tb/sim_dtcl_pwm.sv
module sim_dtcl_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int DT_W  = 6;

  logic clk = 1'b0, rst = 1'b1, lim = 1'b0;
  logic en_ab = 1'b1, en_c = 1'b1, adv = 1'b0;
  logic [CNT_W-1:0] per = 8'd20, cmpa = 8'd8, cmpc = 8'd12, syat = 8'd5;
  logic signed [DT_W-1:0] dt = 6'sd3;
  logic pa, pb, pc, ps;

  int n_run = 0, n_bad = 0;
  int m = 0, ev_e = -1, ev_2 = -1;
  int s_per, s_cmpa, s_cmpc, s_sy, s_dt;
  int q_per, q_cmpa, q_cmpc, q_sy, q_dt;
  int g_force = -1;   // -1 random, -2 none, else event count
  int g_second = -1;
  int g_newcmp = -1;
  string g_tag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  dtcl_pwm #(.CNT_W(CNT_W), .DT_W(DT_W)) u0 (
    .clk(clk), .rst(rst), .lim_i(lim), .en_ab_i(en_ab), .en_c_i(en_c),
    .adv_sync_i(adv), .period_i(per), .cmp_a_i(cmpa), .cmp_c_i(cmpc),
    .sync_at_i(syat), .dead_i(dt), .pwm_a_o(pa), .pwm_b_o(pb),
    .pwm_c_o(pc), .sync_o(ps)
  );

  task automatic chk(input logic got, input bit exp, input string tag, input string what);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s count=%0d actual=%b expected=%b", tag, what, m, got, exp);
    end
  endtask

  task automatic eval_cycle();
    bit acted;
    int fa, fc, sp;
    string tab, tc, tsy;
    acted = en_ab && ev_e >= 0 && ev_e < s_cmpa && ev_e < s_cmpa + ((s_dt < 0) ? s_dt : 0);
    fa  = acted ? ((s_dt < 0) ? ev_e - s_dt : ev_e) : s_cmpa;
    fc  = (en_c && ev_e >= 0 && ev_e < s_cmpc) ? ev_e : s_cmpc;
    sp  = (adv && ev_e >= 0 && ev_e < s_sy) ? ev_e : s_sy;
    tab = (ev_e < 0) ? "R1" : (!acted ? "R4" : ((s_dt < 0) ? "R3" : "R2"));
    tc  = (ev_e < 0) ? "R1" : "R5";
    tsy = "R7";
    if (g_tag != "") begin tab = g_tag; tc = g_tag; tsy = g_tag; end
    chk(pa, m < fa, tab, "A");
    chk(pb, m >= fa + s_dt, tab, "B");
    chk(pc, m < fc, tc, "C");
    chk(ps, m == sp, tsy, "SYNC");
  endtask

  task automatic cfg(input int p, input int ca, input int cc, input int sy, input int d,
                     input bit ab, input bit c, input bit ad);
    rst = 1'b1; lim = 1'b0;
    per = CNT_W'(p); cmpa = CNT_W'(ca); cmpc = CNT_W'(cc); syat = CNT_W'(sy);
    dt = DT_W'(d); en_ab = ab; en_c = c; adv = ad;
    repeat (3) @(negedge clk);
    chk(pa, 1'b0, "R9", "A reset");
    chk(pb, 1'b0, "R9", "B reset");
    chk(pc, 1'b0, "R9", "C reset");
    chk(ps, 1'b0, "R9", "SYNC reset");
    s_per = p; s_cmpa = ca; s_cmpc = cc; s_sy = sy; s_dt = d;
    m = 0;
    rst = 1'b0;
  endtask

  task automatic run(input int nper);
    int done;
    done = 0;
    while (done < nper) begin
      @(negedge clk);
      if (m == 0) begin
        if (g_force == -1)
          ev_e = ($urandom_range(1, 0) == 1) ? int'($urandom_range(s_per - 1, 3)) : -1;
        else if (g_force == -2) ev_e = -1;
        else ev_e = g_force;
        ev_2 = g_second;
      end
      eval_cycle();
      lim = ((ev_e >= 3) && (m == ev_e - 3)) || ((ev_2 >= 3) && (m == ev_2 - 3));
      if (g_newcmp >= 0 && m == 2) begin
        cmpa = CNT_W'(g_newcmp);
        g_newcmp = -1;
      end
      if (m == s_per - 2) begin
        q_per = int'(per); q_cmpa = int'(cmpa); q_cmpc = int'(cmpc);
        q_sy = int'(syat); q_dt = int'(dt);
      end
      if (m == s_per - 1) begin
        m = 0; done++;
        s_per = q_per; s_cmpa = q_cmpa; s_cmpc = q_cmpc; s_sy = q_sy; s_dt = q_dt;
      end else m++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    n_run++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: plain waveforms, no events
    cfg(20, 8, 12, 5, 3, 1, 1, 0); g_force = -2; run(2);
    // R2: positive dead time truncation
    cfg(20, 8, 12, 5, 3, 1, 1, 0); g_force = 5; run(2);
    // R3: negative dead time, B rises at event, A holds |dt|
    cfg(20, 10, 12, 5, -4, 1, 1, 0); g_force = 3; run(2);
    // R4: event after B already rose (negative dead time)
    cfg(20, 10, 12, 5, -4, 1, 1, 0); g_force = 6; run(1);
    // R4: event after A fell normally
    cfg(20, 8, 14, 5, 3, 1, 1, 0); g_force = 12; run(2);
    // R5: C limited while A/B limiting is off
    cfg(20, 8, 12, 5, 3, 0, 1, 0); g_force = 5; run(2);
    // R6: second event in the same period ignored
    g_tag = "R6";
    cfg(24, 14, 16, 20, 2, 1, 1, 0); g_force = 5; g_second = 9; run(2);
    g_second = -1;
    // R8: mid-period compare change waits for next period
    g_tag = "R8";
    cfg(20, 8, 12, 5, 3, 1, 1, 0); g_force = -2; g_newcmp = 14; run(3);
    g_tag = "";
    // R7: sync advance and its absence
    cfg(20, 8, 12, 10, 3, 1, 1, 1); g_force = 4; run(2);
    cfg(20, 8, 12, 10, 3, 1, 1, 1); g_force = 15; run(2);
    cfg(20, 8, 12, 10, 3, 1, 1, 0); g_force = 4; run(2);
    // constrained random mix
    g_force = -1;
    for (int i = 0; i < 40; i++) begin
      int p, ca, cc, sy, d;
      p  = int'($urandom_range(60, 8));
      ca = int'($urandom_range(p - 1, 1));
      cc = int'($urandom_range(p, 1));
      sy = int'($urandom_range(p + 2, 0));
      d  = int'($urandom_range(12, 0)) - 6;
      cfg(p, ca, cc, sy, d, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
          1'($urandom_range(1, 0)));
      run(4);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule